// File: doc/BRIEF.md
# Interrupt Flag Controller

This block is the interrupt logic of a small 8-bit microcontroller core. It collects four event sources into sticky flag bits, each paired with an enable bit:

- an external pin edge, with a selectable polarity;
- a timer overflow pulse;
- a port-change detector with a per-pin mask;
- a conversion-done pulse from the A/D converter.

A global enable gates vectoring. Software reads and writes the registers through a simple port, and only software clears a flag.

While the core sleeps, any enabled source whose flag is set raises a wake-up request, whatever the global enable says. When the core is awake, the block samples the pending state once per instruction cycle, on the cycle tick. If the global enable is set and something is pending, it issues a take pulse and clears the global enable. It then marks two dummy instruction cycles and asks the core to fetch from the fixed vector address. A return strobe from the core sets the global enable again.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After a synchronous reset, the control, peripheral flag, peripheral enable and change mask registers read 00h, and the option register reads 40h (rising edge selected). The outputs wake_req, irq_take, dummy_cyc and vec_fetch are low.
- R2: The register port maps the control register to address 0, the peripheral flag register to 1, the peripheral enable register to 2, the option register to 3, the change mask to 4 and the port level to 5. Bits without a function read 0: control bit 6, every bit of the peripheral flag, peripheral enable and option registers except bit 6, and the mask bits above the pin count.
- R3: The external pin passes through a two-flop synchronizer. When option bit 6 is 1, a rising edge sets control bit 1; when it is 0, a falling edge sets it. The opposite edge leaves the flag clear.
- R4: A tmr_ovf pulse sets control bit 2.
- R5: A change on a pin sets control bit 0 when the pin's change-mask bit is 1 and its analog_sel bit is 0. The change is judged against a latch that is loaded by each read of address 5 with reg_re high. Address 5 returns the synchronized pin levels, with analog pins reading 0.
- R6: An adc_done pulse sets bit 6 of the peripheral flag register.
- R7: No hardware path clears a flag; only a register write of 0 does. If a hardware set and a software write reach the same flag in the same clock, the set wins.
- R8: The enable pairs are control bit 5 with bit 2, bit 4 with bit 1, bit 3 with bit 0, and peripheral enable bit 6 with peripheral flag bit 6. wake_req is high exactly when sleeping is high and at least one pair has both bits set, whatever the state of control bit 7.
- R9: irq_take pulses on a clock where cyc_tick is high, control bit 7 (global enable) is 1, some pair is pending and sleeping is low. The global enable then reads 0.
- R10: After irq_take, dummy_cyc stays high for exactly two instruction cycles. vec_fetch pulses on the second cycle tick after the take, and vec_addr reads 0004h.
- R11: A ret_strobe pulse sets the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock marker of the first quarter of each instruction cycle |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; a read of address 5 reloads the change latch |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ext_pin | input | 1 | External interrupt pin |
| port_pins | input | PINS | Port input pins |
| analog_sel | input | PINS | 1 marks a pin as analog (reads 0, no change detect) |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | Conversion-complete pulse |
| sleeping | input | 1 | Core is in sleep mode |
| ret_strobe | input | 1 | Return-from-interrupt pulse from the core |
| wake_req | output | 1 | Wake-up request to the sleeping core |
| irq_take | output | 1 | Interrupt taken in this instruction cycle |
| dummy_cyc | output | 1 | Core executes a dummy cycle |
| vec_fetch | output | 1 | Fetch from the vector address now |
| vec_addr | output | PC_W | Vector address, 0004h |

## Verification
A software write to the control register and a hardware event that sets a flag can land in the same clock. The bench drives a write of all zeros to the control register on the same edge as a tmr_ovf pulse, then reads the register back and expects the timer flag still set. A second collision comes from the return strobe and a new take: they can occur together, so the global enable is read back after each of them. The wake-up logic is swept over every combination of the four enable and four flag bits, with the global enable clear, and each result is compared with the bitwise AND of the two nibbles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL  = 3'd0,
        A_PFLAG = 3'd1,
        A_PEN   = 3'd2,
        A_OPT   = 3'd3,
        A_MASK  = 3'd4,
        A_PORT  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic gie;
        logic tie;
        logic xie;
        logic cie;
        logic tf;
        logic xf;
        logic cf;
    } ctrl_t;

    typedef struct packed {
        logic tmr;
        logic ext;
        logic chg;
        logic adc;
    } src_vec_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_D1   = 2'd1,
        SEQ_D2   = 2'd2
    } seq_e;

    function automatic logic [7:0] ctrl_pack(ctrl_t c);
        return {c.gie, 1'b0, c.tie, c.xie, c.cie, c.tf, c.xf, c.cf};
    endfunction

    function automatic logic [7:0] bit6_byte(logic b);
        return {1'b0, b, 6'b0};
    endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/irqc_src_detect.sv
module irqc_src_detect #(
    parameter int PINS = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_s,
    input  logic            edge_rise,
    input  logic [PINS-1:0] port_s,
    input  logic [PINS-1:0] analog_sel,
    input  logic [PINS-1:0] chg_mask,
    input  logic            port_rd,
    output logic            ext_hit,
    output logic            chg_hit,
    output logic [PINS-1:0] port_dig
);
    logic            ext_prev;
    logic [PINS-1:0] port_latch;

    assign port_dig = port_s & ~analog_sel;
    assign ext_hit  = edge_rise ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
    assign chg_hit  = |((port_dig ^ port_latch) & chg_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev   <= 1'b0;
            port_latch <= '0;
        end else begin
            ext_prev <= ext_s;
            if (port_rd) port_latch <= port_dig;
        end
    end

    // R5
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        port_rd |=> (port_latch == $past(port_dig)));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int PINS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    input  src_vec_t          hit,
    input  logic              take,
    input  logic              ret,
    output ctrl_t             ctrl,
    output logic              ad_flag,
    output logic              ad_en,
    output logic              edge_rise,
    output logic [PINS-1:0]   chg_mask
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            ad_flag   <= 1'b0;
            ad_en     <= 1'b0;
            edge_rise <= 1'b1;
            chg_mask  <= '0;
        end else begin
            if (we && sel == A_CTRL) begin
                ctrl.gie <= wdata[7];
                ctrl.tie <= wdata[5];
                ctrl.xie <= wdata[4];
                ctrl.cie <= wdata[3];
                ctrl.tf  <= wdata[2];
                ctrl.xf  <= wdata[1];
                ctrl.cf  <= wdata[0];
            end
            if (we && sel == A_PFLAG) ad_flag   <= wdata[6];
            if (we && sel == A_PEN)   ad_en     <= wdata[6];
            if (we && sel == A_OPT)   edge_rise <= wdata[6];
            if (we && sel == A_MASK)  chg_mask  <= wdata[PINS-1:0];
            // hardware sets override a same-cycle software write
            if (hit.tmr) ctrl.tf <= 1'b1;
            if (hit.ext) ctrl.xf <= 1'b1;
            if (hit.chg) ctrl.cf <= 1'b1;
            if (hit.adc) ad_flag <= 1'b1;
            if (ret)     ctrl.gie <= 1'b1;
            if (take)    ctrl.gie <= 1'b0;
        end
    end

    // R4
    tmr_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit.tmr |=> ctrl.tf);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tf && !(we && sel == A_CTRL)) |=> ctrl.tf);
    // R9
    gie_clear_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !ctrl.gie);
    // R11
    ret_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ret && !take) |=> ctrl.gie);
endmodule

// File: rtl/irqc_vector_seq.sv
module irqc_vector_seq
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic gie,
    input  logic pending,
    input  logic sleeping,
    output logic take,
    output logic dummy,
    output logic fetch
);
    seq_e state;

    assign take  = tick && (state == SEQ_IDLE) && gie && pending && !sleeping;
    assign dummy = (state != SEQ_IDLE);
    assign fetch = tick && (state == SEQ_D2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
        end else if (tick) begin
            case (state)
                SEQ_IDLE: if (take) state <= SEQ_D1;
                SEQ_D1:   state <= SEQ_D2;
                SEQ_D2:   state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // R9
    awake_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (!sleeping && gie));
    // R10
    fetch_in_dummy_chk: assert property (@(posedge clk) disable iff (rst)
        fetch |-> dummy);
    // R10
    dummy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (dummy && !fetch));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int              PINS     = 6,
    parameter int              PC_W     = 13,
    parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_tick,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ext_pin,
    input  logic [PINS-1:0]   port_pins,
    input  logic [PINS-1:0]   analog_sel,
    input  logic              tmr_ovf,
    input  logic              adc_done,
    input  logic              sleeping,
    input  logic              ret_strobe,
    output logic              wake_req,
    output logic              irq_take,
    output logic              dummy_cyc,
    output logic              vec_fetch,
    output logic [PC_W-1:0]   vec_addr
);
    localparam int SYNC_W = PINS + 1;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic              ext_s;
    logic [PINS-1:0]   port_s, port_dig, chg_mask;
    logic              ext_hit, chg_hit, edge_rise;
    logic              ad_flag, ad_en, pending, port_rd;
    ctrl_t             ctrl;
    src_vec_t          hit;
    reg_addr_e         sel;

    assign sel     = reg_addr_e'(reg_addr);
    assign sync_in = {ext_pin, port_pins};
    assign ext_s   = sync_out[SYNC_W-1];
    assign port_s  = sync_out[PINS-1:0];
    assign port_rd = reg_re && (sel == A_PORT);

    irqc_sync #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst(rst), .d(sync_in), .q(sync_out)
    );

    irqc_src_detect #(.PINS(PINS)) u_detect (
        .clk(clk), .rst(rst), .ext_s(ext_s), .edge_rise(edge_rise),
        .port_s(port_s), .analog_sel(analog_sel), .chg_mask(chg_mask),
        .port_rd(port_rd), .ext_hit(ext_hit), .chg_hit(chg_hit),
        .port_dig(port_dig)
    );

    assign hit = '{tmr: tmr_ovf, ext: ext_hit, chg: chg_hit, adc: adc_done};

    irqc_regs #(.PINS(PINS)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .hit(hit), .take(irq_take), .ret(ret_strobe),
        .ctrl(ctrl), .ad_flag(ad_flag), .ad_en(ad_en),
        .edge_rise(edge_rise), .chg_mask(chg_mask)
    );

    assign pending = |({ctrl.tie, ctrl.xie, ctrl.cie} & {ctrl.tf, ctrl.xf, ctrl.cf})
                   | (ad_en & ad_flag);
    assign wake_req = sleeping & pending;

    irqc_vector_seq u_seq (
        .clk(clk), .rst(rst), .tick(cyc_tick), .gie(ctrl.gie),
        .pending(pending), .sleeping(sleeping), .take(irq_take),
        .dummy(dummy_cyc), .fetch(vec_fetch)
    );

    assign vec_addr = VEC_ADDR;

    always_comb begin
        reg_rdata = '0;
        case (sel)
            A_CTRL:  reg_rdata = ctrl_pack(ctrl);
            A_PFLAG: reg_rdata = bit6_byte(ad_flag);
            A_PEN:   reg_rdata = bit6_byte(ad_en);
            A_OPT:   reg_rdata = bit6_byte(edge_rise);
            A_MASK:  reg_rdata[PINS-1:0] = chg_mask;
            A_PORT:  reg_rdata[PINS-1:0] = port_dig;
            default: reg_rdata = '0;
        endcase
    end

    // R8
    wake_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> !wake_req);
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    localparam int PINS = 6;

    logic clk = 0, rst = 1, cyc_tick = 0;
    logic reg_we = 0, reg_re = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic ext_pin = 0;
    logic [PINS-1:0] port_pins = 0, analog_sel = 0;
    logic tmr_ovf = 0, adc_done = 0, sleeping = 0, ret_strobe = 0;
    logic wake_req, irq_take, dummy_cyc, vec_fetch;
    logic [12:0] vec_addr;

    int checks = 0, fails = 0;
    int tick_count = 0, takes = 0, fetches = 0, gap = 0, take_at = 0, dummy_clks = 0;
    int phase = 0;

    always #2 clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .reg_we(reg_we),
        .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ext_pin(ext_pin), .port_pins(port_pins),
        .analog_sel(analog_sel), .tmr_ovf(tmr_ovf), .adc_done(adc_done),
        .sleeping(sleeping), .ret_strobe(ret_strobe), .wake_req(wake_req),
        .irq_take(irq_take), .dummy_cyc(dummy_cyc), .vec_fetch(vec_fetch),
        .vec_addr(vec_addr)
    );

    always @(posedge clk) begin
        #1;
        cyc_tick <= (phase == 3);
        phase <= (phase + 1) % 4;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (irq_take) begin takes++; take_at = tick_count; dummy_clks = 0; end
            if (dummy_cyc) dummy_clks++;
            if (vec_fetch) begin fetches++; gap = tick_count - take_at; end
            if (cyc_tick) tick_count++;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_port(output logic [7:0] d);
        @(negedge clk);
        reg_addr = 3'd5; reg_re = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 0;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_ovf = 1;
        @(negedge clk); tmr_ovf = 0;
    endtask

    initial begin
        #600000;
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int t0;
        wait_clk(4);
        rst = 0;
        wait_clk(2);
        // R1 reset values
        rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(3'd1, d); chk("R1 pflag", d, 8'h00);
        rd(3'd2, d); chk("R1 pen", d, 8'h00);
        rd(3'd3, d); chk("R1 opt", d, 8'h40);
        rd(3'd4, d); chk("R1 mask", d, 8'h00);
        chk("R1 outputs", {wake_req, irq_take, dummy_cyc, vec_fetch}, 0);
        // R2 map and unused bits
        wr(3'd1, 8'hFF); rd(3'd1, d); chk("R2 pflag", d, 8'h40);
        wr(3'd2, 8'hFF); rd(3'd2, d); chk("R2 pen", d, 8'h40);
        wr(3'd3, 8'hFF); rd(3'd3, d); chk("R2 opt", d, 8'h40);
        wr(3'd4, 8'hFF); rd(3'd4, d); chk("R2 mask", d, 8'h3F);
        wr(3'd0, 8'h7F); rd(3'd0, d); chk("R2 ctrl", d, 8'h3F);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd4, 8'h00);
        // R3 edge polarity sweep
        for (int sel = 0; sel < 2; sel++) begin
            for (int rise = 0; rise < 2; rise++) begin
                wr(3'd3, sel[0] ? 8'h40 : 8'h00);
                ext_pin = ~rise[0];
                wait_clk(6);
                wr(3'd0, 8'h00);
                ext_pin = rise[0];
                wait_clk(6);
                rd(3'd0, d);
                chk($sformatf("R3 sel%0d rise%0d", sel, rise), d[1], (sel == rise) ? 1 : 0);
            end
        end
        ext_pin = 0; wait_clk(6); wr(3'd0, 8'h00);
        // R4 timer
        pulse_tmr(); rd(3'd0, d); chk("R4 timer flag", d, 8'h04);
        wr(3'd0, 8'h00);
        // R5 port change sweep
        for (int p = 0; p < PINS; p++) begin
            for (int m = 0; m < 2; m++) begin
                for (int an = 0; an < 2; an++) begin
                    wr(3'd4, m[0] ? 8'(1 << p) : 8'h00);
                    analog_sel = an[0] ? PINS'(1 << p) : '0;
                    rd_port(d);
                    wr(3'd0, 8'h00);
                    port_pins = PINS'(1 << p);
                    wait_clk(6);
                    rd(3'd0, d);
                    chk($sformatf("R5 pin%0d m%0d a%0d", p, m, an), d[0], (m == 1 && an == 0) ? 1 : 0);
                    rd_port(d);
                    chk("R5 port level", d, an[0] ? 0 : (1 << p));
                    wr(3'd0, 8'h00);
                    wait_clk(4);
                    rd(3'd0, d);
                    chk("R5 rearmed", d[0], 0);
                    port_pins = '0;
                    wait_clk(6);
                    rd_port(d);
                    wr(3'd0, 8'h00);
                end
            end
        end
        analog_sel = '0; wr(3'd4, 8'h00);
        // R6 adc
        @(negedge clk); adc_done = 1; @(negedge clk); adc_done = 0;
        rd(3'd1, d); chk("R6 adc flag", d, 8'h40);
        wr(3'd1, 8'h00);
        // R7 collision: write 0 and timer set in same clock
        @(negedge clk); reg_we = 1; reg_addr = 3'd0; reg_wdata = 8'h00; tmr_ovf = 1;
        @(negedge clk); reg_we = 0; tmr_ovf = 0;
        rd(3'd0, d); chk("R7 set wins", d, 8'h04);
        wait_clk(10);
        rd(3'd0, d); chk("R7 sticky", d, 8'h04);
        wr(3'd0, 8'h00); rd(3'd0, d); chk("R7 sw clear", d, 8'h00);
        // R8 wake sweep with global enable clear
        sleeping = 1;
        t0 = takes;
        for (int e = 0; e < 16; e++) begin
            for (int f = 0; f < 16; f++) begin
                wr(3'd0, {2'b00, e[2:0], f[2:0]});
                wr(3'd2, {1'b0, e[3], 6'b0});
                wr(3'd1, {1'b0, f[3], 6'b0});
                @(negedge clk); #1;
                chk($sformatf("R8 e%0h f%0h", e, f), wake_req, ((e & f) != 0) ? 1 : 0);
            end
        end
        chk("R8 no take without gie", takes, t0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        // R8/R9 asleep with gie: wake but no take until awake
        wr(3'd0, 8'hA0);
        pulse_tmr();
        wait_clk(12);
        chk("R8 wake with gie", wake_req, 1);
        chk("R9 no take asleep", takes, t0);
        sleeping = 0;
        wait_clk(20);
        chk("R9 take after wake", takes, t0 + 1);
        rd(3'd0, d); chk("R9 gie cleared", d, 8'h24);
        chk("R10 fetch count", fetches, 1);
        chk("R10 gap ticks", gap, 2);
        chk("R10 dummy clocks", dummy_clks, 8);
        chk("R10 vector", vec_addr, 13'h0004);
        // R11 return strobe
        wr(3'd0, 8'h20);
        @(negedge clk); ret_strobe = 1; @(negedge clk); ret_strobe = 0;
        rd(3'd0, d); chk("R11 gie set", d, 8'hA0);
        // second take from awake state
        pulse_tmr();
        wait_clk(20);
        chk("R9 second take", takes, t0 + 2);
        chk("R10 second gap", gap, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule